// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

This block holds four independent down-counters behind a small word-addressed register bus, together with one shared interrupt group. Each channel counts on ticks from its own prescaler (divide by 1, 16 or 256). When it reaches zero, it raises its own status bit. The next tick then either wraps to the all-ones value, reloads from a background register, or leaves the counter parked at zero. A channel can count over its full 32 bits or over its low 16 bits only. Software measures elapsed time by inverting the value it reads back.

The interrupt group keeps a raw status word, a mask and a masked view. A single interrupt line is driven whenever any unmasked status bit is set. Status bits are cleared by writing ones to a dedicated clear word. Addresses are byte addresses, and bits 1:0 are ignored. The shared words sit at word indices 0 to 3. Channel n owns word indices 4(n+1) to 4(n+1)+3.

Top module: `mcd_timer_unit`

## Requirements
- R1: After a synchronous reset every readable word is zero, `rdata` is zero and `irq` is low.
- R2: A write to a channel's load word (group offset 0x0) puts the written value into the counter on the same clock edge and restarts that channel's prescaler. The load word reads back the last value written to it.
- R3: While control bit 7 (run) is clear, the counter keeps its value. The only change comes from a load write.
- R4: Control bits 3:2 pick the tick rate: 00 gives one tick per clock, 01 one tick per 16 clocks, 10 one tick per 256 clocks, and 11 behaves like 00. The first tick after a load comes 1, 16 or 256 clocks later.
- R5: Each tick decrements the counter by one. The tick that moves it from 1 to 0 sets raw status bit n for channel n (bits 3:0 map to channels 0 to 3). The current value reads at group offset 0x4.
- R6: When control bit 0 (single-shot) is set, a counter at zero stays at zero and raises no further status bits until a new load value is written.
- R7: When bit 0 is clear and bit 6 (auto-reload) is set, the tick after zero copies the background word (group offset 0xC) into the counter. Writing the background word leaves the running count untouched.
- R8: When bits 0 and 6 are both clear, the tick after zero wraps the counter to all ones of the active width: 0xFFFF or 0xFFFFFFFF.
- R9: Control bit 1 set gives a 32-bit counter. When it is clear, only the low 16 bits count, and the current-value word reads with its upper 16 bits as zero.
- R10: The masked status word (0x08) equals raw status (0x04) AND the mask word (0x00). `irq` is high exactly when the masked status is non-zero.
- R11: Writing ones to the clear word (0x0C) clears those raw bits. A zero-crossing on the same edge keeps its bit set. Writes to the raw and masked words are ignored, and the clear word reads as zero.
- R12: Control words (group offset 0x8) read back only bits 7, 6, 3, 2, 1 and 0, with every other bit zero. Addresses beyond the last channel group read as zero.
- R13: `rdata` is registered. It shows the addressed word one clock after `rd_en` and holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe; data appears on `rdata` one clock later |
| addr | input | ADDR_W (7) | Byte address; bits 1:0 ignored |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | OR of the masked status bits |

## Verification
Directed sequences cover each reload policy separately. A single-shot channel parks at zero. An auto-reload channel returns to its background value, which is changed while the channel runs. Free-running channels wrap in both 16-bit and 32-bit width, so the two wrap values are told apart. Prescaler settings are probed on both sides of the 256-clock boundary and with the 11 encoding. A zero-crossing is lined up with a clear write on the same edge, which shows that the set wins.

A seeded random phase then mixes reads, writes of small load values and random control words across all addresses, including unmapped ones. Every read and every cycle of `irq` is compared against a cycle-level model. This catches ordering faults between load writes, prescaler restarts and status updates that the directed cases do not reach.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // control word bit positions
  localparam int CTL_RUN_B    = 7;
  localparam int CTL_AUTO_B   = 6;
  localparam int CTL_DIV_HI_B = 3;
  localparam int CTL_DIV_LO_B = 2;
  localparam int CTL_WIDE_B   = 1;
  localparam int CTL_ONCE_B   = 0;

  // bits of the control word that are stored and read back
  localparam logic [7:0] CTL_KEEP = 8'hCF;

  // word offsets inside a channel group
  typedef enum logic [1:0] {
    CH_LOAD = 2'd0,
    CH_CURR = 2'd1,
    CH_CTRL = 2'd2,
    CH_BGND = 2'd3
  } ch_word_e;

  // word offsets inside the shared interrupt group
  typedef enum logic [1:0] {
    SH_MASK  = 2'd0,
    SH_RAW   = 2'd1,
    SH_MASKD = 2'd2,
    SH_CLR   = 2'd3
  } sh_word_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] limit;

  // terminal count per divide setting; 2'b11 behaves as divide-by-1
  always_comb begin
    case (sel)
      2'b01:   limit = PS_W'(15);
      2'b10:   limit = PS_W'(255);
      default: limit = '0;
    endcase
  end

  // >= so that lowering the divide mid-count does not stall
  assign tick = run && !restart && (ps_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ps_q <= '0;
    end else if (run) begin
      ps_q <= tick ? '0 : ps_q + PS_W'(1);
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PS_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic              wr_bgnd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_rd,
  output logic [DATA_W-1:0] cur_rd,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] bgnd_rd,
  output logic              zero_hit
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] bgnd_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_d;
  logic [DATA_W-1:0] span;
  logic [DATA_W-1:0] cur;
  logic [7:0]        ctrl_q;
  logic              tick;

  assign span = ctrl_q[CTL_WIDE_B] ? {DATA_W{1'b1}}
                                   : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign cur  = cnt_q & span;

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q[CTL_RUN_B]),
    .restart (wr_load),
    .sel     (ctrl_q[CTL_DIV_HI_B:CTL_DIV_LO_B]),
    .tick    (tick)
  );

  // next count: a load write wins over a tick
  always_comb begin
    cnt_d    = cnt_q;
    zero_hit = 1'b0;
    if (wr_load) begin
      cnt_d = wdata;
    end else if (tick) begin
      if (cur == DATA_W'(1)) begin
        cnt_d    = '0;
        zero_hit = 1'b1;
      end else if (cur == '0) begin
        if (ctrl_q[CTL_ONCE_B]) begin
          cnt_d = cnt_q;
        end else if (ctrl_q[CTL_AUTO_B]) begin
          cnt_d = bgnd_q & span;
        end else begin
          cnt_d = span;
        end
      end else begin
        cnt_d = cur - DATA_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      bgnd_q <= '0;
      ctrl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_load) load_q <= wdata;
      if (wr_bgnd) bgnd_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata[7:0] & CTL_KEEP;
    end
  end

  assign load_rd = load_q;
  assign cur_rd  = cur;
  assign ctrl_rd = {{(DATA_W-8){1'b0}}, ctrl_q};
  assign bgnd_rd = bgnd_q;

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_mask,
  input  logic           wr_clr,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] events,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] masked,
  output logic           irq
);

  logic [NCH-1:0] clr_bits;

  assign clr_bits = wr_clr ? wbits : '0;

  // a zero-crossing on the clearing edge keeps its bit
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | events;
      if (wr_mask) mask_q <= wbits;
    end
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

endmodule

// File: rtl/mcd_timer_unit.sv
module mcd_timer_unit
  import tmr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 32,
  parameter int PS_W   = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int WIDX_W = ADDR_W - 2;
  localparam int GRP_W  = WIDX_W - 2;

  logic [WIDX_W-1:0] word;
  logic [1:0]        wsel;
  logic              sh_hit;
  logic [NCH-1:0]    grp_hit;

  logic [NCH-1:0]              wr_ld_v;
  logic [NCH-1:0]              wr_ct_v;
  logic [NCH-1:0]              wr_bg_v;
  logic [NCH-1:0]              uf_v;
  logic [NCH-1:0][DATA_W-1:0]  ld_v;
  logic [NCH-1:0][DATA_W-1:0]  cur_v;
  logic [NCH-1:0][DATA_W-1:0]  ctl_v;
  logic [NCH-1:0][DATA_W-1:0]  bg_v;
  logic [NCH-1:0][7:0]         ctl8;

  logic              wr_mask;
  logic              wr_clr;
  logic [NCH-1:0]    mask_st;
  logic [NCH-1:0]    raw_st;
  logic [NCH-1:0]    mis_st;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign word   = addr[ADDR_W-1:2];
  assign wsel   = word[1:0];
  assign sh_hit = (word[WIDX_W-1:2] == '0);

  assign wr_mask = wr_en && sh_hit && (wsel == 2'(SH_MASK));
  assign wr_clr  = wr_en && sh_hit && (wsel == 2'(SH_CLR));

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      assign grp_hit[ch] = (word[WIDX_W-1:2] == GRP_W'(ch + 1));
      assign wr_ld_v[ch] = wr_en && grp_hit[ch] && (wsel == 2'(CH_LOAD));
      assign wr_ct_v[ch] = wr_en && grp_hit[ch] && (wsel == 2'(CH_CTRL));
      assign wr_bg_v[ch] = wr_en && grp_hit[ch] && (wsel == 2'(CH_BGND));
      assign ctl8[ch]    = ctl_v[ch][7:0];

      tmr_channel #(
        .DATA_W (DATA_W),
        .PS_W   (PS_W)
      ) u_chan (
        .clk      (clk),
        .rst      (rst),
        .wr_load  (wr_ld_v[ch]),
        .wr_ctrl  (wr_ct_v[ch]),
        .wr_bgnd  (wr_bg_v[ch]),
        .wdata    (wdata),
        .load_rd  (ld_v[ch]),
        .cur_rd   (cur_v[ch]),
        .ctrl_rd  (ctl_v[ch]),
        .bgnd_rd  (bg_v[ch]),
        .zero_hit (uf_v[ch])
      );
    end
  endgenerate

  tmr_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .wr_mask (wr_mask),
    .wr_clr  (wr_clr),
    .wbits   (wdata[NCH-1:0]),
    .events  (uf_v),
    .mask_q  (mask_st),
    .raw_q   (raw_st),
    .masked  (mis_st),
    .irq     (irq)
  );

  // read decode
  always_comb begin
    rd_mux = '0;
    if (sh_hit) begin
      case (wsel)
        2'(SH_MASK):  rd_mux = DATA_W'(mask_st);
        2'(SH_RAW):   rd_mux = DATA_W'(raw_st);
        2'(SH_MASKD): rd_mux = DATA_W'(mis_st);
        default:      rd_mux = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (grp_hit[i]) begin
        case (wsel)
          2'(CH_LOAD): rd_mux = ld_v[i];
          2'(CH_CURR): rd_mux = cur_v[i];
          2'(CH_CTRL): rd_mux = ctl_v[i];
          default:     rd_mux = bg_v[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/tmr_unit_checker.sv
module tmr_unit_checker #(
  parameter int NCH    = 4,
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      irq,
  input logic [NCH-1:0]            raw,
  input logic [NCH-1:0]            uf,
  input logic [NCH-1:0]            ldw,
  input logic [NCH-1:0][DATA_W-1:0] cur,
  input logic [NCH-1:0][7:0]       ctl,
  input logic                      clrw,
  input logic [NCH-1:0]            wbits
);

  // R1: reset empties status and drops the interrupt
  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (raw == '0) && !irq);

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_chk
      // R3: a stopped channel keeps its value unless loaded or its width changes
      assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl[ch][7] && !ldw[ch]) |=>
          ((cur[ch] == $past(cur[ch])) || (ctl[ch][1] != $past(ctl[ch][1]))));

      // R5: a zero-crossing leaves the counter at zero and latches its status bit
      assert_cross_zero_R5: assert property (@(posedge clk) disable iff (rst)
        uf[ch] |=> (cur[ch] == '0) && raw[ch]);

      // R6: a single-shot channel parked at zero stays there
      assert_oneshot_park_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl[ch][7] && ctl[ch][0] && (cur[ch] == '0) && !ldw[ch]) |=>
          ((cur[ch] == '0) || (ctl[ch][1] != $past(ctl[ch][1]))));

      // R11: a clear without a simultaneous crossing empties the bit
      assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (clrw && wbits[ch] && !uf[ch]) |=> !raw[ch]);
    end
  endgenerate

endmodule

bind mcd_timer_unit tmr_unit_checker #(
  .NCH    (NCH),
  .DATA_W (DATA_W)
) u_checker (
  .clk   (clk),
  .rst   (rst),
  .irq   (irq),
  .raw   (raw_st),
  .uf    (uf_v),
  .ldw   (wr_ld_v),
  .cur   (cur_v),
  .ctl   (ctl8),
  .clrw  (wr_clr),
  .wbits (wdata[NCH-1:0])
);

// File: tb/tb_mcd_timer_unit.sv
module tb_mcd_timer_unit;

  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 7;

  logic          clk   = 1'b0;
  logic          rst   = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr  = '0;
  logic [DW-1:0] wdata = '0;
  wire  [DW-1:0] rdata;
  wire           irq;

  always #10 clk = ~clk;

  mcd_timer_unit #(.NCH(NCH), .DATA_W(DW), .PS_W(8), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [DW-1:0]  m_load [NCH];
  logic [DW-1:0]  m_bg   [NCH];
  logic [DW-1:0]  m_cnt  [NCH];
  logic [7:0]     m_ctl  [NCH];
  int             m_ps   [NCH];
  logic [NCH-1:0] m_mask;
  logic [NCH-1:0] m_raw;
  logic [DW-1:0]  m_rd;
  bit             m_rd_new;
  string          m_rd_tag;

  function automatic logic [DW-1:0] span_of(input logic [7:0] c);
    return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic int lim_of(input logic [7:0] c);
    case (c[3:2])
      2'b01:   return 15;
      2'b10:   return 255;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    int w;
    w = int'(a) / 4;
    if (w < 4) begin
      case (w)
        0: return "R10";
        1: return "R5";
        2: return "R10";
        default: return "R11";
      endcase
    end else if (w < 4 + 4 * NCH) begin
      case (w % 4)
        0: return "R2";
        1: return "R5";
        2: return "R12";
        default: return "R7";
      endcase
    end
    return "R12";
  endfunction

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    int w, c;
    w = int'(a) / 4;
    if (w == 0) return DW'(m_mask);
    if (w == 1) return DW'(m_raw);
    if (w == 2) return DW'(m_raw & m_mask);
    if (w < 4 || w >= 4 + 4 * NCH) return '0;
    c = (w - 4) / 4;
    case (w % 4)
      0: return m_load[c];
      1: return m_cnt[c] & span_of(m_ctl[c]);
      2: return DW'(m_ctl[c]);
      default: return m_bg[c];
    endcase
  endfunction

  always @(posedge clk) begin : model_step
    logic [NCH-1:0] ev;
    logic [NCH-1:0] clr;
    int             w;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_load[c] = '0; m_bg[c] = '0; m_cnt[c] = '0; m_ctl[c] = '0; m_ps[c] = 0;
      end
      m_mask = '0; m_raw = '0; m_rd = '0; m_rd_new = 1'b0;
    end else begin
      if (rd_en) begin
        m_rd     = model_read(addr);
        m_rd_tag = tag_of(addr);
        m_rd_new = 1'b1;
      end else begin
        m_rd_new = 1'b0;
      end
      w  = int'(addr) / 4;
      ev = '0;
      for (int c = 0; c < NCH; c++) begin
        logic [DW-1:0] sp;
        logic [DW-1:0] cur;
        int            g;
        g   = 4 + 4 * c;
        sp  = span_of(m_ctl[c]);
        cur = m_cnt[c] & sp;
        if (wr_en && w == g) begin
          m_cnt[c] = wdata;
          m_ps[c]  = 0;
        end else if (m_ctl[c][7]) begin
          if (m_ps[c] >= lim_of(m_ctl[c])) begin
            m_ps[c] = 0;
            if (cur == 1) begin
              m_cnt[c] = '0;
              ev[c]    = 1'b1;
            end else if (cur == 0) begin
              if (m_ctl[c][0])      m_cnt[c] = m_cnt[c];
              else if (m_ctl[c][6]) m_cnt[c] = m_bg[c] & sp;
              else                  m_cnt[c] = sp;
            end else begin
              m_cnt[c] = cur - 1;
            end
          end else begin
            m_ps[c] = m_ps[c] + 1;
          end
        end
        if (wr_en && w == g)     m_load[c] = wdata;
        if (wr_en && w == g + 2) m_ctl[c]  = wdata[7:0] & 8'hCF;
        if (wr_en && w == g + 3) m_bg[c]   = wdata;
      end
      clr   = (wr_en && w == 3) ? wdata[NCH-1:0] : '0;
      m_raw = (m_raw & ~clr) | ev;
      if (wr_en && w == 0) m_mask = wdata[NCH-1:0];
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(irq == |(m_raw & m_mask), "R10", DW'(irq), DW'(|(m_raw & m_mask)));
      if (m_rd_new) chk(rdata == m_rd, {m_rd_tag, " R13"}, rdata, m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  function automatic logic [AW-1:0] ch_addr(input int c, input int r);
    return AW'(16 + 16 * c + 4 * r);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R1: watchdog expired, got timeout expected completion");
    finish_run();
  end

  initial begin : stimulus
    logic [DW-1:0] v1, v2;
    int            seed_val;
    seed_val = int'($urandom(32'd20240611));
    idle(3);
    rst = 1'b0;

    // R1: reset state
    chk(rdata == '0, "R1", rdata, '0);
    chk(irq == 1'b0, "R1", DW'(irq), '0);
    for (int w = 0; w < 4 + 4 * NCH; w++) rd_exp(AW'(4 * w), '0, "R1");

    // R12: reserved control bits and unmapped space
    wr(ch_addr(1, 2), 32'hFFFF_FFFF);
    rd_exp(ch_addr(1, 2), 32'h0000_00CF, "R12");
    wr(ch_addr(1, 2), 32'h0);
    rd_exp(AW'(7'h50), '0, "R12");
    rd_exp(AW'(7'h7C), '0, "R12");

    // R2 / R3: load while stopped
    wr(ch_addr(0, 0), 32'd5);
    rd_exp(ch_addr(0, 1), 32'd5, "R2");
    idle(5);
    rd_exp(ch_addr(0, 1), 32'd5, "R3");
    rd_exp(ch_addr(0, 0), 32'd5, "R2");

    // R9: width selection on the current value
    wr(ch_addr(0, 0), 32'h1234_5678);
    rd_exp(ch_addr(0, 1), 32'h0000_5678, "R9");
    wr(ch_addr(0, 2), 32'h02);
    rd_exp(ch_addr(0, 1), 32'h1234_5678, "R9");
    wr(ch_addr(0, 2), 32'h00);

    // R6 / R5 / R10 / R11: single-shot on channel 2
    wr(ch_addr(2, 0), 32'd3);
    wr(ch_addr(2, 2), 32'h83);
    idle(10);
    rd_exp(ch_addr(2, 1), '0, "R6");
    rd_exp(AW'(7'h04), 32'h4, "R5");
    chk(irq == 1'b0, "R10", DW'(irq), '0);
    wr(AW'(7'h00), 32'h4);
    chk(irq == 1'b1, "R10", DW'(irq), 32'h1);
    rd_exp(AW'(7'h08), 32'h4, "R10");
    wr(AW'(7'h04), 32'h0);
    rd_exp(AW'(7'h04), 32'h4, "R11");
    wr(AW'(7'h0C), 32'h4);
    chk(irq == 1'b0, "R11", DW'(irq), '0);
    rd_exp(AW'(7'h04), '0, "R11");
    rd_exp(AW'(7'h0C), '0, "R11");
    idle(20);
    rd_exp(AW'(7'h04), '0, "R6");
    rd_exp(ch_addr(2, 1), '0, "R6");
    wr(ch_addr(2, 0), 32'd2);
    idle(5);
    rd_exp(AW'(7'h04), 32'h4, "R6");
    wr(ch_addr(2, 2), 32'h0);
    wr(AW'(7'h0C), 32'h4);
    wr(AW'(7'h00), 32'h0);

    // R8: free-running wrap, 16-bit then 32-bit, channel 3
    wr(ch_addr(3, 0), 32'd2);
    wr(ch_addr(3, 2), 32'h80);
    idle(4);
    rd_exp(ch_addr(3, 1), 32'h0000_FFFE, "R8");
    wr(ch_addr(3, 2), 32'h0);
    wr(ch_addr(3, 0), 32'd1);
    wr(ch_addr(3, 2), 32'h82);
    idle(2);
    rd_exp(ch_addr(3, 1), 32'hFFFF_FFFF, "R8");
    wr(ch_addr(3, 2), 32'h0);
    rd(ch_addr(3, 1), v1);
    idle(3);
    rd(ch_addr(3, 1), v2);
    chk(v1 == v2, "R3", v2, v1);
    wr(AW'(7'h0C), 32'hF);

    // R7 / R4: auto-reload with divide-by-16, channel 1
    wr(ch_addr(1, 0), 32'd1);
    wr(ch_addr(1, 3), 32'd4);
    wr(ch_addr(1, 2), 32'hC6);
    idle(35);
    rd_exp(ch_addr(1, 1), 32'd4, "R7");
    wr(ch_addr(1, 3), 32'd9);
    rd_exp(ch_addr(1, 1), 32'd4, "R7");
    idle(74);
    rd_exp(ch_addr(1, 1), 32'd9, "R7");
    rd_exp(AW'(7'h04), 32'h2, "R5");
    wr(ch_addr(1, 2), 32'h0);
    wr(AW'(7'h0C), 32'hF);

    // R4: divide-by-256 and the 11 encoding, channel 0
    wr(ch_addr(0, 2), 32'h8A);
    wr(ch_addr(0, 0), 32'd1000);
    idle(250);
    rd_exp(ch_addr(0, 1), 32'd1000, "R4");
    idle(48);
    rd_exp(ch_addr(0, 1), 32'd999, "R4");
    wr(ch_addr(0, 2), 32'h8E);
    wr(ch_addr(0, 0), 32'd100);
    idle(9);
    rd_exp(ch_addr(0, 1), 32'd91, "R4");
    wr(ch_addr(0, 2), 32'h0);

    // R11: crossing and clear on the same edge
    wr(AW'(7'h0C), 32'hF);
    wr(ch_addr(0, 2), 32'h82);
    wr(ch_addr(0, 0), 32'd3);
    idle(2);
    wr(AW'(7'h0C), 32'h1);
    rd_exp(AW'(7'h04), 32'h1, "R11");
    wr(ch_addr(0, 2), 32'h0);
    wr(AW'(7'h0C), 32'hF);

    // random phase, checked by the model (R2..R13)
    for (int it = 0; it < 4000; it++) begin
      int op, w;
      logic [DW-1:0] d;
      op = int'($urandom % 4);
      w  = int'($urandom % 22);
      if (op == 0) begin
        idle(1 + int'($urandom % 3));
      end else if (op == 1) begin
        rd(AW'(4 * w), v1);
      end else begin
        if (w >= 4 && (w % 4) == 2) d = {$urandom} | 32'h80;
        else if (w >= 4)            d = $urandom % 64;
        else                        d = $urandom;
        wr(AW'(4 * w), d);
      end
    end
    idle(2);
    finish_run();
  end

endmodule